// File: doc/BRIEF.md
# ADC Test-Pattern Link Checker

This block observes deserialized 12-bit converter words together with their valid strobe. It compares each word against a known pattern chosen by a mode input, so faults in the serial link and the deserializer become visible. A walking-one mode exposes bits that land in the wrong position. An all-bits toggle mode exposes words whose low and high bits come from neighbouring samples. A ramp mode exposes dropped, repeated or reordered samples by requiring a counting sequence.

For every valid word the block reports a registered match flag and the XOR mask of the bits that differed. It also keeps a sticky error flag and a saturating error count. These clear on a synchronous clear or on any change of mode. The checker never drives the converter or the link. It only watches words.

Top module: `adc_pattern_checker`

## Requirements
- R1: After reset, `match` is 0, `err_sticky` is 0, `err_cnt` is 0 and `diff_mask` is 0.
- R2: With `mode` = 2'b00 (walking one), the expected word has a single 1 at bit `one_pos` (bit 0 is the LSB) and zeros elsewhere. Any other word is a mismatch.
- R3: With `mode` = 2'b01 (toggle), every word must be all ones or all zeros. The first valid word after a mode change sets the phase from its bit 11. Each later valid word is expected to be the inverse of the previous expected word.
- R4: In toggle mode, a split word whose bits disagree is a mismatch, and `diff_mask` marks exactly the bits that differ from the expected level.
- R5: With `mode` = 2'b10 (ramp), the first valid word after a mode change only seeds the sequence. Each later valid word must equal the previous received word plus 1 modulo 4096, so 0xFFF is followed by 0x000.
- R6: One cycle after a valid word, `diff_mask` holds the received word XOR the expected word, and `match` is 1 exactly when that mask is zero.
- R7: A mismatching valid word sets `err_sticky` and adds one to `err_cnt`.
- R8: `err_cnt` is 16 bits wide and stays at 0xFFFF once it reaches that value.
- R9: A cycle with `clr` high, or with `mode` different from its value in the previous cycle, clears `err_cnt` and `err_sticky`. A valid word in that cycle still updates `match` and `diff_mask` but is not counted.
- R10: With `mode` = 2'b11 (off), valid words leave `match`, `diff_mask`, `err_cnt` and `err_sticky` unchanged.
- R11: In cycles without `din_vld`, `match` and `diff_mask` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the error flag and count |
| mode | input | 2 | Pattern select: 00 walking one, 01 toggle, 10 ramp, 11 off |
| one_pos | input | 4 | Bit position of the 1 in walking-one mode |
| din | input | 12 | Deserialized sample word |
| din_vld | input | 1 | Sample word valid |
| match | output | 1 | Last valid word equalled the expected word |
| err_sticky | output | 1 | At least one mismatch since the last clear |
| err_cnt | output | 16 | Saturating mismatch count |
| diff_mask | output | 12 | Received XOR expected for the last valid word |

## Verification
A wrong toggle phase or a wrong ramp seed shows on the next valid word. It appears as a full-width `diff_mask` in toggle mode, or as a low-order carry pattern in ramp mode, one cycle after that word. A mode-change detector that fails to fire leaves `err_cnt` and `err_sticky` nonzero in the cycle after the change. A stale seed flag makes the first word of a new mode report a mismatch. Saturation faults only become visible after 65535 consecutive mismatches, so one long error burst is driven on purpose.

// File: rtl/adc_pattern_checker.sv
module adc_pattern_checker #(
  parameter int W  = 12,
  parameter int CW = 16,
  parameter int PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [1:0]    mode,
  input  logic [PW-1:0] one_pos,
  input  logic [W-1:0]  din,
  input  logic          din_vld,
  output logic          match,
  output logic          err_sticky,
  output logic [CW-1:0] err_cnt,
  output logic [W-1:0]  diff_mask
);

  localparam logic [1:0]    M_WALK = 2'd0;
  localparam logic [1:0]    M_TOG  = 2'd1;
  localparam logic [1:0]    M_RAMP = 2'd2;
  localparam logic [1:0]    M_OFF  = 2'd3;
  localparam logic [CW-1:0] CMAX   = '1;
  localparam logic [PW-1:0] LAST   = PW'(W - 1);
  localparam logic [W-1:0]  ONE    = {{(W-1){1'b0}}, 1'b1};

  logic [1:0]   mode_q;
  logic         seeded;
  logic         phase;
  logic [W-1:0] prev;
  logic [W-1:0] expw;

  wire mode_chg = (mode != mode_q);
  wire restart  = clr | mode_chg;
  wire primed   = seeded & ~mode_chg;
  wire active   = din_vld & (mode != M_OFF);

  always_comb begin
    case (mode)
      M_WALK:  expw = (one_pos <= LAST) ? (ONE << one_pos) : '0;
      M_TOG:   expw = {W{primed ? phase : din[W-1]}};
      M_RAMP:  expw = primed ? prev + ONE : din;
      default: expw = din;
    endcase
  end

  wire [W-1:0] diff = din ^ expw;
  wire         bad  = |diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= M_WALK;
      seeded     <= 1'b0;
      phase      <= 1'b0;
      prev       <= '0;
      match      <= 1'b0;
      diff_mask  <= '0;
      err_sticky <= 1'b0;
      err_cnt    <= '0;
    end else begin
      mode_q <= mode;
      if (mode_chg) seeded <= 1'b0;
      if (active) begin
        match     <= ~bad;
        diff_mask <= diff;
        seeded    <= 1'b1;
        prev      <= din;
        phase     <= ~expw[W-1];
      end
      if (restart) begin
        err_sticky <= 1'b0;
        err_cnt    <= '0;
      end else if (active && bad) begin
        err_sticky <= 1'b1;
        if (err_cnt != CMAX) err_cnt <= err_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_pattern_checker_sva.sv
module adc_pattern_checker_sva #(
  parameter int W  = 12,
  parameter int CW = 16,
  parameter int PW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic [1:0]    mode,
  input logic [PW-1:0] one_pos,
  input logic [W-1:0]  din,
  input logic          din_vld,
  input logic          match,
  input logic          err_sticky,
  input logic [CW-1:0] err_cnt,
  input logic [W-1:0]  diff_mask
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  a_r2_walk_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (din_vld && mode == 2'd0 && $stable(mode) && din == (ONE << one_pos)) |=> match);

  a_r6_match_is_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    din_vld |=> (match == (diff_mask == '0)));

  a_r7_count_implies_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != '0) |-> err_sticky);

  a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !clr && $stable(mode)) |=> err_sticky);

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && $stable(mode)) |=> (err_cnt >= $past(err_cnt)));

  a_r8_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == '1 && !clr && $stable(mode)) |=> (err_cnt == '1));

  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !din_vld |=> ($stable(match) && $stable(diff_mask)));

endmodule

bind adc_pattern_checker adc_pattern_checker_sva #(.W(W), .CW(CW), .PW(PW)) u_sva (
  .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .one_pos(one_pos),
  .din(din), .din_vld(din_vld), .match(match), .err_sticky(err_sticky),
  .err_cnt(err_cnt), .diff_mask(diff_mask)
);

// File: tb/adc_pattern_checker_test.sv
module adc_pattern_checker_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  one_pos = 4'd0;
  logic [11:0] din = '0;
  logic        din_vld = 1'b0;
  logic        match, err_sticky;
  logic [15:0] err_cnt;
  logic [11:0] diff_mask;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_pattern_checker uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .one_pos(one_pos),
    .din(din), .din_vld(din_vld), .match(match), .err_sticky(err_sticky),
    .err_cnt(err_cnt), .diff_mask(diff_mask)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] w);
    @(negedge clk);
    din = w; din_vld = 1'b1;
    @(negedge clk);
    din_vld = 1'b0; din = 12'hA5A;
  endtask

  task automatic expect_word(input bit m, input logic [11:0] mk, input string tag);
    chk(match == m, {tag, " match"}, int'(match), int'(m));
    chk(diff_mask == mk, {tag, " mask"}, int'(diff_mask), int'(mk));
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(match == 1'b0, "R1 match", int'(match), 0);
    chk(err_sticky == 1'b0, "R1 sticky", int'(err_sticky), 0);
    chk(err_cnt == 16'd0, "R1 cnt", int'(err_cnt), 0);
    chk(diff_mask == 12'd0, "R1 mask", int'(diff_mask), 0);
  endtask

  task automatic t_walk();
    one_pos = 4'd5;
    send(12'h020); expect_word(1'b1, 12'h000, "R2 pos5 hit");
    send(12'h040); expect_word(1'b0, 12'h060, "R2 R6 pos5 miss");
    chk(err_cnt == 16'd1, "R7 cnt", int'(err_cnt), 1);
    chk(err_sticky == 1'b1, "R7 sticky", int'(err_sticky), 1);
    one_pos = 4'd11;
    send(12'h800); expect_word(1'b1, 12'h000, "R2 pos11 hit");
    chk(err_sticky == 1'b1, "R7 sticky kept", int'(err_sticky), 1);
    repeat (3) @(negedge clk);
    expect_word(1'b1, 12'h000, "R11 idle hold");
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk(err_cnt == 16'd0, "R9 clr cnt", int'(err_cnt), 0);
    chk(err_sticky == 1'b0, "R9 clr sticky", int'(err_sticky), 0);
    send(12'h001); expect_word(1'b0, 12'h801, "R2 wrong bit");
  endtask

  task automatic t_toggle();
    set_mode(2'd1);
    chk(err_cnt == 16'd0, "R9 mode change cnt", int'(err_cnt), 0);
    chk(err_sticky == 1'b0, "R9 mode change sticky", int'(err_sticky), 0);
    send(12'hFFF); expect_word(1'b1, 12'h000, "R3 seed ones");
    send(12'h000); expect_word(1'b1, 12'h000, "R3 alt zeros");
    send(12'hFFF); expect_word(1'b1, 12'h000, "R3 alt ones");
    send(12'h03F); expect_word(1'b0, 12'h03F, "R4 split");
    chk(err_cnt == 16'd1, "R4 cnt", int'(err_cnt), 1);
    send(12'hFFF); expect_word(1'b1, 12'h000, "R3 after split");
    send(12'hFFF); expect_word(1'b0, 12'hFFF, "R3 no alternation");
  endtask

  task automatic t_ramp();
    set_mode(2'd2);
    send(12'hFFE); expect_word(1'b1, 12'h000, "R5 seed");
    send(12'hFFF); expect_word(1'b1, 12'h000, "R5 step");
    send(12'h000); expect_word(1'b1, 12'h000, "R5 wrap");
    send(12'h002); expect_word(1'b0, 12'h003, "R5 skip");
    send(12'h003); expect_word(1'b1, 12'h000, "R5 resync");
    chk(err_cnt == 16'd1, "R5 cnt", int'(err_cnt), 1);
  endtask

  task automatic t_off();
    set_mode(2'd3);
    send(12'h000);
    send(12'h123);
    chk(match == 1'b1, "R10 off match", int'(match), 1);
    chk(diff_mask == 12'h000, "R10 off mask", int'(diff_mask), 0);
    chk(err_cnt == 16'd0, "R10 off cnt", int'(err_cnt), 0);
  endtask

  task automatic t_same_cycle_clear();
    set_mode(2'd0);
    one_pos = 4'd0;
    @(negedge clk);
    clr = 1'b1; din = 12'h004; din_vld = 1'b1;
    @(negedge clk);
    clr = 1'b0; din_vld = 1'b0;
    expect_word(1'b0, 12'h005, "R9 clr with word");
    chk(err_cnt == 16'd0, "R9 clr word not counted", int'(err_cnt), 0);
  endtask

  task automatic t_saturate();
    @(negedge clk);
    din = 12'h000; din_vld = 1'b1;
    repeat (70000) @(negedge clk);
    din_vld = 1'b0;
    chk(err_cnt == 16'hFFFF, "R8 saturate", int'(err_cnt), 16'hFFFF);
    chk(err_sticky == 1'b1, "R8 sticky", int'(err_sticky), 1);
    chk(diff_mask == 12'h001, "R8 mask", int'(diff_mask), 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_walk();
    t_toggle();
    t_ramp();
    t_off();
    t_same_cycle_clear();
    t_saturate();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule